// File: doc/BRIEF.md
# Display Memory Port and Bank Controller

This block sits between a small processor's I/O bus and the display subsystem of a character terminal. It decodes four I/O port addresses. Two of them give access to a CRT timing controller: one selects that controller's internal register and one carries register data in either direction. A third port clears a latched real-time-clock interrupt. The fourth port is written as a control byte and read back as a status byte with a different meaning in its top bit.

The control byte selects one of sixteen memory banks and picks 40- or 80-column mode. It enables the real-time-clock interrupt, blanks the video and maps a 2 KB video RAM over the top 2 KB of the banked address space.

The block also arbitrates the video RAM address between the CPU and the CRT controller. A CPU access that lands in the mapped video window is given the memory only while the character clock is low. While the character clock is high the CPU is held with a wait signal.

Top module: `dpc_top`

## Requirements
- R1: An I/O write to 0xFC pulses `crtc_idx_we` in the same cycle. An I/O write to 0xFD pulses `crtc_dat_we`. An I/O read of 0xFD raises `crtc_dat_re` and returns `crtc_rdata` on `io_rdata`. At most one of these strobes is high at a time.
- R2: An I/O write to 0xFF updates the control outputs at the next clock edge: `bank_sel` = data[3:0], `col40` = data[4], `rtc_ie` = data[5], `video_blank` = data[6], `vram_map` = data[7].
- R3: An I/O read of 0xFF returns {`kbd_irq`, `video_blank`, `rtc_ie`, `col40`, 4'b0000} with bit 7 first.
- R4: While reset is asserted, and after it is released, `bank_sel`, `vram_map`, `video_blank`, `col40`, `rtc_ie` and `rtc_irq` are 0.
- R5: An `rtc_tick` pulse sets `rtc_irq` at the next edge only when `rtc_ie` is 1. Ticks seen while `rtc_ie` is 0 leave `rtc_irq` at 0.
- R6: An I/O write to 0xFE clears `rtc_irq` at the next edge. If a tick arrives in the same cycle as that write, the clear wins.
- R7: A CPU request counts as a video hit when `vram_map` is 1 and `cpu_addr` lies in 0xF800 to 0xFFFF. A hit raises `vram_cs`. Any other request raises `bank_cs`. The two are never high together.
- R8: During a video hit with `cclk` low, `mux_cpu` is 1 and `vram_addr` = `cpu_addr[10:0]`. Otherwise `mux_cpu` is 0 and `vram_addr` = `crt_addr`.
- R9: `cpu_wait` is 1 exactly when there is a video hit while `cclk` is high.
- R10: Reads of any address other than 0xFD and 0xFF return 0. Writes to any address other than 0xFC to 0xFF change no control output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write strobe, one cycle |
| io_rd | input | 1 | I/O read strobe |
| io_rdata | output | 8 | I/O read data, 0 when not reading |
| crtc_idx_we | output | 1 | CRT controller index write strobe |
| crtc_dat_we | output | 1 | CRT controller data write strobe |
| crtc_dat_re | output | 1 | CRT controller data read strobe |
| crtc_rdata | input | 8 | Data returned by the CRT controller |
| rtc_tick | input | 1 | Real-time-clock tick, one cycle |
| kbd_irq | input | 1 | Keyboard interrupt pending |
| rtc_irq | output | 1 | Latched real-time-clock interrupt |
| bank_sel | output | 4 | Memory bank number |
| vram_map | output | 1 | Video RAM mapped over the top 2 KB |
| video_blank | output | 1 | Video display off |
| col40 | output | 1 | 40-column mode |
| rtc_ie | output | 1 | Real-time-clock interrupt enable |
| cclk | input | 1 | Character clock level |
| cpu_req | input | 1 | CPU memory request |
| cpu_addr | input | 16 | CPU memory address |
| crt_addr | input | 11 | CRT controller refresh address |
| vram_cs | output | 1 | Video RAM select |
| bank_cs | output | 1 | Bank RAM select |
| mux_cpu | output | 1 | Video address multiplexer gives the CPU the bus |
| cpu_wait | output | 1 | Hold the CPU off |
| vram_addr | output | 11 | Video RAM address |

## Verification
The hardest case to reach is a real-time-clock tick and a clear write landing in the same cycle. The flag must first be set, which needs the enable bit written through the control port and an earlier tick. The bench builds that state step by step and then drives the tick and the 0xFE write on the same falling edge. A second hard case is the wait window. It needs the video map bit set first, then an address inside the top window, then both levels of the character clock. The bench walks those combinations after programming the control port.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  // Control byte layout; bit positions are visible to software
  typedef struct packed {
    logic       vram_map;
    logic       vid_off;
    logic       rtc_ie;
    logic       col40;
    logic [3:0] bank;
  } ctrl_t;

  typedef enum logic [2:0] {
    PSEL_NONE,
    PSEL_IDX,
    PSEL_DATA,
    PSEL_CLR,
    PSEL_CTRL
  } psel_e;

endpackage

// File: rtl/dpc_port_decode.sv
module dpc_port_decode #(
  parameter int              IO_AW  = 8,
  parameter logic [IO_AW-1:0] P_IDX  = 8'hFC,
  parameter logic [IO_AW-1:0] P_DATA = 8'hFD,
  parameter logic [IO_AW-1:0] P_CLR  = 8'hFE,
  parameter logic [IO_AW-1:0] P_CTRL = 8'hFF
) (
  input  logic [IO_AW-1:0] io_addr,
  input  logic             io_wr,
  input  logic             io_rd,
  output logic             idx_we,
  output logic             dat_we,
  output logic             dat_re,
  output logic             clr_we,
  output logic             ctrl_we,
  output logic             ctrl_re
);
  import dpc_pkg::*;

  psel_e sel;

  always_comb begin
    if      (io_addr == P_IDX)  sel = PSEL_IDX;
    else if (io_addr == P_DATA) sel = PSEL_DATA;
    else if (io_addr == P_CLR)  sel = PSEL_CLR;
    else if (io_addr == P_CTRL) sel = PSEL_CTRL;
    else                        sel = PSEL_NONE;
  end

  always_comb begin
    idx_we  = 1'b0;
    dat_we  = 1'b0;
    dat_re  = 1'b0;
    clr_we  = 1'b0;
    ctrl_we = 1'b0;
    ctrl_re = 1'b0;
    unique case (sel)
      PSEL_IDX:  idx_we = io_wr;
      PSEL_DATA: begin
        dat_we = io_wr;
        dat_re = io_rd & ~io_wr;
      end
      PSEL_CLR:  clr_we = io_wr;
      PSEL_CTRL: begin
        ctrl_we = io_wr;
        ctrl_re = io_rd & ~io_wr;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dpc_ctrl_reg.sv
module dpc_ctrl_reg (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [7:0]     wdata,
  output dpc_pkg::ctrl_t q
);
  import dpc_pkg::*;

  ctrl_t q_nxt;

  always_comb begin
    q_nxt = q;
    if (we) q_nxt = ctrl_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/dpc_rtc_flag.sv
module dpc_rtc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ie,
  input  logic clr,
  output logic flag
);

  logic flag_nxt;

  // Clear has priority over a tick in the same cycle
  always_comb begin
    flag_nxt = flag;
    if (clr)            flag_nxt = 1'b0;
    else if (tick & ie) flag_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_nxt;
  end

endmodule

// File: rtl/dpc_mem_arb.sv
module dpc_mem_arb #(
  parameter int ADDR_W  = 16,
  parameter int VRAM_AW = 11
) (
  input  logic               cpu_req,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [VRAM_AW-1:0] crt_addr,
  input  logic               cclk,
  input  logic               vram_map,
  output logic               vram_cs,
  output logic               bank_cs,
  output logic               mux_cpu,
  output logic               cpu_wait,
  output logic [VRAM_AW-1:0] vram_addr
);
  localparam int HI_W = ADDR_W - VRAM_AW;

  logic in_win;
  logic hit;

  generate
    if (HI_W > 0) begin : g_win
      assign in_win = &cpu_addr[ADDR_W-1:VRAM_AW];
    end else begin : g_full
      assign in_win = 1'b1;
    end
  endgenerate

  always_comb begin
    hit       = cpu_req & vram_map & in_win;
    vram_cs   = hit;
    bank_cs   = cpu_req & ~hit;
    mux_cpu   = hit & ~cclk;
    cpu_wait  = hit & cclk;
    vram_addr = mux_cpu ? cpu_addr[VRAM_AW-1:0] : crt_addr;
  end

endmodule

// File: rtl/dpc_top.sv
module dpc_top #(
  parameter int ADDR_W  = 16,
  parameter int VRAM_AW = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         io_addr,
  input  logic [7:0]         io_wdata,
  input  logic               io_wr,
  input  logic               io_rd,
  output logic [7:0]         io_rdata,
  output logic               crtc_idx_we,
  output logic               crtc_dat_we,
  output logic               crtc_dat_re,
  input  logic [7:0]         crtc_rdata,
  input  logic               rtc_tick,
  input  logic               kbd_irq,
  output logic               rtc_irq,
  output logic [3:0]         bank_sel,
  output logic               vram_map,
  output logic               video_blank,
  output logic               col40,
  output logic               rtc_ie,
  input  logic               cclk,
  input  logic               cpu_req,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [VRAM_AW-1:0] crt_addr,
  output logic               vram_cs,
  output logic               bank_cs,
  output logic               mux_cpu,
  output logic               cpu_wait,
  output logic [VRAM_AW-1:0] vram_addr
);
  import dpc_pkg::*;

  // Reset: asserted asynchronously, released after two edges
  logic [1:0] rst_sync;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  logic  clr_we, ctrl_we, ctrl_re;
  ctrl_t ctrl;

  dpc_port_decode u_dec (
    .io_addr (io_addr),
    .io_wr   (io_wr),
    .io_rd   (io_rd),
    .idx_we  (crtc_idx_we),
    .dat_we  (crtc_dat_we),
    .dat_re  (crtc_dat_re),
    .clr_we  (clr_we),
    .ctrl_we (ctrl_we),
    .ctrl_re (ctrl_re)
  );

  dpc_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst_n (rst_s),
    .we    (ctrl_we),
    .wdata (io_wdata),
    .q     (ctrl)
  );

  dpc_rtc_flag u_rtc (
    .clk   (clk),
    .rst_n (rst_s),
    .tick  (rtc_tick),
    .ie    (ctrl.rtc_ie),
    .clr   (clr_we),
    .flag  (rtc_irq)
  );

  dpc_mem_arb #(.ADDR_W(ADDR_W), .VRAM_AW(VRAM_AW)) u_arb (
    .cpu_req   (cpu_req),
    .cpu_addr  (cpu_addr),
    .crt_addr  (crt_addr),
    .cclk      (cclk),
    .vram_map  (ctrl.vram_map),
    .vram_cs   (vram_cs),
    .bank_cs   (bank_cs),
    .mux_cpu   (mux_cpu),
    .cpu_wait  (cpu_wait),
    .vram_addr (vram_addr)
  );

  assign bank_sel    = ctrl.bank;
  assign vram_map    = ctrl.vram_map;
  assign video_blank = ctrl.vid_off;
  assign col40       = ctrl.col40;
  assign rtc_ie      = ctrl.rtc_ie;

  // Status read layout differs from the control write layout in bit 7
  always_comb begin
    io_rdata = '0;
    if (crtc_dat_re)  io_rdata = crtc_rdata;
    else if (ctrl_re) io_rdata = {kbd_irq, ctrl.vid_off, ctrl.rtc_ie, ctrl.col40, 4'b0000};
  end

endmodule

// File: rtl/dpc_chk.sv
module dpc_chk #(
  parameter int ADDR_W  = 16,
  parameter int VRAM_AW = 11
) (
  input logic               clk,
  input logic               rst_s,
  input logic [7:0]         io_addr,
  input logic [7:0]         io_wdata,
  input logic               io_wr,
  input logic               io_rd,
  input logic [7:0]         io_rdata,
  input logic               crtc_idx_we,
  input logic               crtc_dat_we,
  input logic               crtc_dat_re,
  input logic               rtc_tick,
  input logic               kbd_irq,
  input logic               rtc_irq,
  input logic [3:0]         bank_sel,
  input logic               vram_map,
  input logic               video_blank,
  input logic               col40,
  input logic               rtc_ie,
  input logic               cclk,
  input logic               cpu_req,
  input logic [ADDR_W-1:0]  cpu_addr,
  input logic               vram_cs,
  input logic               bank_cs,
  input logic               mux_cpu,
  input logic               cpu_wait
);

  p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0({crtc_idx_we, crtc_dat_we, crtc_dat_re}));

  p_ctrl_latch_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (io_wr && io_addr == 8'hFF) |=>
      (bank_sel == $past(io_wdata[3:0]) && col40 == $past(io_wdata[4]) &&
       rtc_ie == $past(io_wdata[5]) && video_blank == $past(io_wdata[6]) &&
       vram_map == $past(io_wdata[7])));

  p_status_read_r3: assert property (@(posedge clk) disable iff (!rst_s)
    (io_rd && !io_wr && io_addr == 8'hFF) |->
      (io_rdata[3:0] == 4'b0000 && io_rdata[7] == kbd_irq && io_rdata[6] == video_blank));

  p_tick_gated_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (!rtc_ie && !rtc_irq) |=> !rtc_irq);

  p_tick_sets_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (rtc_tick && rtc_ie && !(io_wr && io_addr == 8'hFE)) |=> rtc_irq);

  p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (io_wr && io_addr == 8'hFE) |=> !rtc_irq);

  p_sel_excl_r7: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0({vram_cs, bank_cs}));

  p_vram_needs_map_r7: assert property (@(posedge clk) disable iff (!rst_s)
    vram_cs |-> (vram_map && cpu_req && (&cpu_addr[ADDR_W-1:VRAM_AW])));

  p_mux_low_r8: assert property (@(posedge clk) disable iff (!rst_s)
    mux_cpu |-> (!cclk && vram_cs));

  p_wait_high_r9: assert property (@(posedge clk) disable iff (!rst_s)
    cpu_wait |-> (cclk && vram_cs && !mux_cpu));

  p_no_ghost_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (io_wr && io_addr < 8'hFC) |=> $stable({bank_sel, vram_map, video_blank, col40, rtc_ie}));

endmodule

bind dpc_top dpc_chk #(.ADDR_W(ADDR_W), .VRAM_AW(VRAM_AW)) u_chk (
  .clk         (clk),
  .rst_s       (rst_s),
  .io_addr     (io_addr),
  .io_wdata    (io_wdata),
  .io_wr       (io_wr),
  .io_rd       (io_rd),
  .io_rdata    (io_rdata),
  .crtc_idx_we (crtc_idx_we),
  .crtc_dat_we (crtc_dat_we),
  .crtc_dat_re (crtc_dat_re),
  .rtc_tick    (rtc_tick),
  .kbd_irq     (kbd_irq),
  .rtc_irq     (rtc_irq),
  .bank_sel    (bank_sel),
  .vram_map    (vram_map),
  .video_blank (video_blank),
  .col40       (col40),
  .rtc_ie      (rtc_ie),
  .cclk        (cclk),
  .cpu_req     (cpu_req),
  .cpu_addr    (cpu_addr),
  .vram_cs     (vram_cs),
  .bank_cs     (bank_cs),
  .mux_cpu     (mux_cpu),
  .cpu_wait    (cpu_wait)
);

// File: tb/dpc_top_tb.sv
`timescale 1ns/1ps
module dpc_top_tb;

  logic        clk, rst_n;
  logic [7:0]  io_addr, io_wdata, io_rdata, crtc_rdata;
  logic        io_wr, io_rd;
  logic        crtc_idx_we, crtc_dat_we, crtc_dat_re;
  logic        rtc_tick, kbd_irq, rtc_irq;
  logic [3:0]  bank_sel;
  logic        vram_map, video_blank, col40, rtc_ie;
  logic        cclk, cpu_req;
  logic [15:0] cpu_addr;
  logic [10:0] crt_addr, vram_addr;
  logic        vram_cs, bank_cs, mux_cpu, cpu_wait;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  dpc_top u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
    .crtc_idx_we(crtc_idx_we), .crtc_dat_we(crtc_dat_we), .crtc_dat_re(crtc_dat_re),
    .crtc_rdata(crtc_rdata), .rtc_tick(rtc_tick), .kbd_irq(kbd_irq), .rtc_irq(rtc_irq),
    .bank_sel(bank_sel), .vram_map(vram_map), .video_blank(video_blank), .col40(col40),
    .rtc_ie(rtc_ie), .cclk(cclk), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .crt_addr(crt_addr), .vram_cs(vram_cs), .bank_cs(bank_cs), .mux_cpu(mux_cpu),
    .cpu_wait(cpu_wait), .vram_addr(vram_addr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic tick_once();
    @(negedge clk);
    rtc_tick = 1'b1;
    @(negedge clk);
    rtc_tick = 1'b0;
  endtask

  // {kbd_irq, written control byte, expected status byte}
  localparam logic [16:0] VEC [0:5] = '{
    {1'b0, 8'hA5, 8'h20},
    {1'b1, 8'h5A, 8'hD0},
    {1'b1, 8'hFF, 8'hF0},
    {1'b0, 8'h00, 8'h00},
    {1'b0, 8'h3C, 8'h30},
    {1'b1, 8'hC7, 8'hC0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; io_addr = 8'h00; io_wdata = 8'h00; io_wr = 1'b0; io_rd = 1'b0;
    crtc_rdata = 8'h00; rtc_tick = 1'b0; kbd_irq = 1'b0; cclk = 1'b0;
    cpu_req = 1'b0; cpu_addr = 16'h0000; crt_addr = 11'h000;
    repeat (3) @(negedge clk);
    chk("R4 reset ctrl", {8'h0, bank_sel, vram_map, video_blank, col40, rtc_ie}, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 after release", {bank_sel, vram_map, video_blank, col40, rtc_ie, rtc_irq}, 16'h0000);

    // R2 / R3 table walk
    foreach (VEC[i]) begin
      io_write(8'hFF, VEC[i][15:8]);
      chk("R2 bank_sel", {12'h0, bank_sel}, {12'h0, VEC[i][11:8]});
      chk("R2 flags", {12'h0, vram_map, video_blank, rtc_ie, col40},
          {12'h0, VEC[i][15], VEC[i][14], VEC[i][13], VEC[i][12]});
      kbd_irq = VEC[i][16]; io_addr = 8'hFF; io_rd = 1'b1;
      #1;
      chk("R3 status read", {8'h0, io_rdata}, {8'h0, VEC[i][7:0]});
      @(negedge clk);
      io_rd = 1'b0; kbd_irq = 1'b0;
    end

    // R1 strobes and data read
    @(negedge clk);
    io_addr = 8'hFC; io_wdata = 8'h0E; io_wr = 1'b1; #1;
    chk("R1 index strobe", {13'h0, crtc_idx_we, crtc_dat_we, crtc_dat_re}, 16'h0004);
    @(negedge clk);
    io_addr = 8'hFD; #1;
    chk("R1 data write strobe", {13'h0, crtc_idx_we, crtc_dat_we, crtc_dat_re}, 16'h0002);
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b1; crtc_rdata = 8'h6B; #1;
    chk("R1 data read strobe", {13'h0, crtc_idx_we, crtc_dat_we, crtc_dat_re}, 16'h0001);
    chk("R1 data read value", {8'h0, io_rdata}, 16'h006B);

    // R10 unused addresses
    @(negedge clk);
    io_addr = 8'h10; #1;
    chk("R10 unused read", {8'h0, io_rdata}, 16'h0000);
    io_rd = 1'b0;
    io_write(8'hFF, 8'h4B);
    io_write(8'h10, 8'hB4);
    io_write(8'hFB, 8'hB4);
    chk("R10 unused write", {8'h0, vram_map, video_blank, rtc_ie, col40, bank_sel}, 16'h004B);

    // R5 tick gating
    io_write(8'hFF, 8'h00);
    tick_once();
    chk("R5 tick ignored when disabled", {15'h0, rtc_irq}, 16'h0000);
    io_write(8'hFF, 8'h20);
    chk("R5 no flag without tick", {15'h0, rtc_irq}, 16'h0000);
    tick_once();
    chk("R5 tick sets flag", {15'h0, rtc_irq}, 16'h0001);

    // R6 clear, and clear against simultaneous tick
    io_write(8'hFE, 8'h00);
    chk("R6 clear", {15'h0, rtc_irq}, 16'h0000);
    tick_once();
    chk("R6 flag set again", {15'h0, rtc_irq}, 16'h0001);
    @(negedge clk);
    rtc_tick = 1'b1; io_addr = 8'hFE; io_wr = 1'b1;
    @(negedge clk);
    rtc_tick = 1'b0; io_wr = 1'b0;
    chk("R6 clear beats tick", {15'h0, rtc_irq}, 16'h0000);

    // R7 R8 R9 arbitration
    io_write(8'hFF, 8'h80);
    cpu_req = 1'b1; cpu_addr = 16'hF900; crt_addr = 11'h2A5; cclk = 1'b1; #1;
    chk("R9 wait while cclk high", {12'h0, vram_cs, bank_cs, mux_cpu, cpu_wait}, 16'h0009);
    chk("R8 crt address while cclk high", {5'h0, vram_addr}, 16'h02A5);
    @(negedge clk);
    cclk = 1'b0; #1;
    chk("R8 cpu owns mux when cclk low", {12'h0, vram_cs, bank_cs, mux_cpu, cpu_wait}, 16'h000A);
    chk("R8 cpu address passed", {5'h0, vram_addr}, 16'h0100);
    @(negedge clk);
    cpu_addr = 16'hF7FF; cclk = 1'b1; #1;
    chk("R7 below window is bank", {12'h0, vram_cs, bank_cs, mux_cpu, cpu_wait}, 16'h0004);
    @(negedge clk);
    cpu_addr = 16'hFFFF; #1;
    chk("R7 top of window is video", {12'h0, vram_cs, bank_cs, mux_cpu, cpu_wait}, 16'h0009);
    cpu_req = 1'b0;
    io_write(8'hFF, 8'h03);
    cpu_req = 1'b1; #1;
    chk("R7 unmapped goes to bank", {12'h0, vram_cs, bank_cs, mux_cpu, cpu_wait}, 16'h0004);
    chk("R8 unmapped keeps crt address", {5'h0, vram_addr}, 16'h02A5);
    @(negedge clk);
    cpu_req = 1'b0;

    // R4 reset in mid-run
    io_write(8'hFF, 8'hF7);
    tick_once();
    @(negedge clk);
    rst_n = 1'b0; #1;
    chk("R4 async clear", {bank_sel, vram_map, video_blank, col40, rtc_ie, rtc_irq}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 state after second reset", {bank_sel, vram_map, video_blank, col40, rtc_ie, rtc_irq}, 16'h0000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule